// File: doc/BRIEF.md
# Buddy Block Allocator

This block manages a pool of 2^POOL_LOG2 equal units (256 by default) and hands out regions whose size is a power of two number of units. A client asks for a number of units. The block rounds that number up to a power of two, takes the lowest-addressed free block of that size, and returns its first unit index. If only a larger block is free, the block halves it step by step until a block of the needed size exists. Each unused half stays free.

A client returns a region by giving its first unit index and its order, where order k means 2^k units. The released block then joins its partner block repeatedly while the partner is also free, so the pool regains larger blocks. The partner of an order-k block at index a sits at a XOR 2^k. The block handles one command at a time over several cycles. It signals readiness and produces a one-cycle response that carries either a base and order or a failure flag.

Top module: `buddy_alloc`

## Requirements
- R1: After reset, `ready` is 1, `respValid` is 0, and the whole pool is a single free block of order POOL_LOG2. A first request for 256 units, or for any smaller size, succeeds at base 0.
- R2: An allocation of size s (1 to 2^POOL_LOG2) is served with `respOrder` equal to the smallest k for which 2^k >= s. `respBase` is always a multiple of 2^respOrder.
- R3: An allocation takes the lowest-addressed free block of the smallest order that is at least the needed order. While that block is larger than needed, it is halved: the upper half becomes free and the lower half is used. For example, 21 units from an empty pool give base 0 and order 5, leaving free blocks at 32 (order 5), 64 (order 6) and 128 (order 7).
- R4: An allocation of size 0, of a size above 2^POOL_LOG2, or of a size that no free block can hold responds with `respFail`=1, `respBase`=0 and `respOrder`=0, and leaves every block's state unchanged.
- R5: A free of a block at base b and order k marks it free. While its partner at b XOR 2^k is free and k < POOL_LOG2, the two join into one block of order k+1 at the lower base. The response reports the base and order of the final merged block.
- R6: A free responds with `respFail`=1 and changes nothing when the order exceeds POOL_LOG2, when the base is not a multiple of 2^order, or when the named block overlaps any block that is already free (the block itself, a block containing it, or a block inside it).
- R7: A command is taken on a clock edge where `ready` is 1 and a valid input is high. `ready` is 0 from the next cycle until the response. `respValid` is high for exactly one cycle, and `ready` returns to 1 in the cycle after it.
- R8: When `allocValid` and `freeValid` are both high in a cycle where `ready` is 1, only the allocation is carried out and the free request has no effect.
- R9: No free block ever lies inside another free block, so after every allocated block has been returned, the pool is again one free block of order POOL_LOG2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| allocValid | input | 1 | Allocation command present |
| allocSize | input | POOL_LOG2+1 | Requested number of units |
| freeValid | input | 1 | Release command present |
| freeBase | input | POOL_LOG2 | First unit index of the block being released |
| freeOrder | input | ORD_W | Order of the block being released (size 2^order) |
| ready | output | 1 | Block is idle and takes a command this cycle |
| respValid | output | 1 | One-cycle response strobe |
| respFail | output | 1 | Command rejected or could not be served |
| respBase | output | POOL_LOG2 | Base of the allocated block or of the merged free block |
| respOrder | output | ORD_W | Order of that block |

## Verification
The hardest state to reach from the ports is a fragmented pool. Such a pool holds free blocks of many orders side by side, so a single release runs a merge cascade over several levels and stops at an allocated partner. A release that overlaps a free sub-block is also only possible in that state. The stimulus builds this layout on purpose by allocating sizes 2, 3 and 1 from a split order-6 block, then returns the pieces in an order that forces one-level merges, rejected overlapping releases, and finally a four-level cascade. Failed allocations are each followed by a successful one whose expected base proves that nothing moved.

// File: rtl/buddy_pkg.sv
package buddy_pkg;

  // strobes from the sequencer to the block-state datapath
  typedef struct packed {
    logic loadAlloc;   // capture needed order, start search there
    logic loadFree;    // capture target node of a release
    logic stepUp;      // search one order higher
    logic takeFound;   // claim the lowest free node of the current order
    logic splitStep;   // free the upper half, descend into the lower half
    logic mergeStep;   // absorb the free partner, move one order up
    logic markFree;    // set the current node free
    logic respOk;      // register base/order of the current node
    logic respFail;    // register a failure response
  } dpCtl_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SEARCH,
    ST_SPLIT,
    ST_MERGE,
    ST_DONE
  } ctlState_t;

endpackage

// File: rtl/buddy_dp.sv
module buddy_dp
  import buddy_pkg::*;
#(
  parameter int POOL_LOG2 = 8,
  localparam int ORD_W = $clog2(POOL_LOG2 + 1)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  dpCtl_t               ctl,
  input  logic [POOL_LOG2:0]   allocSize,
  input  logic [POOL_LOG2-1:0] freeBase,
  input  logic [ORD_W-1:0]     freeOrder,
  input  logic                 respValid,
  output logic                 allocBad,
  output logic                 freeBad,
  output logic                 found,
  output logic                 atTop,
  output logic                 atNeed,
  output logic                 buddyFree,
  output logic [POOL_LOG2-1:0] respBase,
  output logic [ORD_W-1:0]     respOrder,
  output logic                 respFail
);

  localparam int POOL  = 1 << POOL_LOG2;
  localparam int NODES = 2 * POOL;       // tree nodes 1 .. NODES-1
  localparam int NW    = POOL_LOG2 + 1;  // node index width

  // one free bit per tree node; node 1 is the whole pool
  logic [NODES-1:1]    freeMap;
  logic [NW-1:0]       curNode;
  logic [ORD_W-1:0]    curOrder;
  logic [ORD_W-1:0]    needOrder;
  logic                lastWasFree;

  function automatic logic [NW-1:0] nodeOf(input logic [POOL_LOG2-1:0] b,
                                           input logic [ORD_W-1:0] k);
    logic [NW-1:0] lvl;
    logic [NW-1:0] idx;
    lvl = NW'(1) << (POOL_LOG2 - int'(k));
    idx = NW'(b >> k);
    return lvl | idx;
  endfunction

  function automatic logic [POOL_LOG2-1:0] baseOf(input logic [NW-1:0] n,
                                                  input logic [ORD_W-1:0] k);
    logic [NW-1:0] lvl;
    logic [NW-1:0] idx;
    lvl = NW'(1) << (POOL_LOG2 - int'(k));
    idx = (n & ~lvl) << k;
    return idx[POOL_LOG2-1:0];
  endfunction

  // ---------------- allocation size decode ----------------
  logic [ORD_W-1:0] allocNeed;

  always_comb begin
    allocNeed = '0;
    for (int k = POOL_LOG2; k >= 0; k--) begin
      if ((1 << k) >= int'(allocSize)) allocNeed = ORD_W'(k);
    end
    allocBad = (allocSize == '0) || (int'(allocSize) > POOL);
  end

  // ---------------- lowest free node at current order ----------------
  logic [NW-1:0] foundNode;
  logic [NW-1:0] searchLvl;
  logic [NW-1:0] candNode;
  int            searchCnt;

  always_comb begin
    searchLvl = NW'(1) << (POOL_LOG2 - int'(curOrder));
    searchCnt = 1 << (POOL_LOG2 - int'(curOrder));
    found     = 1'b0;
    foundNode = searchLvl;
    candNode  = searchLvl;
    for (int i = POOL - 1; i >= 0; i--) begin
      candNode = searchLvl + NW'(i);
      if (i < searchCnt && freeMap[candNode]) begin
        found     = 1'b1;
        foundNode = candNode;
      end
    end
  end

  // ---------------- release argument check ----------------
  logic             orderOk;
  logic             aligned;
  logic             overlapFree;
  logic [ORD_W-1:0] tOrder;
  logic [NW-1:0]    tNode;
  logic [NW-1:0]    alignMask;
  int               tDepth;

  always_comb begin
    orderOk   = int'(freeOrder) <= POOL_LOG2;
    tOrder    = orderOk ? freeOrder : ORD_W'(POOL_LOG2);
    tNode     = nodeOf(freeBase, tOrder);
    tDepth    = POOL_LOG2 - int'(tOrder);
    alignMask = (NW'(1) << tOrder) - NW'(1);
    aligned   = (NW'(freeBase) & alignMask) == '0;
    overlapFree = 1'b0;
    // the node itself and every enclosing node
    for (int d = 0; d <= POOL_LOG2; d++) begin
      if (d <= tDepth && freeMap[tNode >> (tDepth - d)]) overlapFree = 1'b1;
    end
    // every node inside the target block
    for (int d = 1; d <= POOL_LOG2; d++) begin
      for (int i = 0; i < (1 << d); i++) begin
        if (d > tDepth && ((NW'((1 << d) + i) >> (d - tDepth)) == tNode)
            && freeMap[NW'((1 << d) + i)]) overlapFree = 1'b1;
      end
    end
    freeBad = !orderOk || !aligned || overlapFree;
  end

  // ---------------- status to sequencer ----------------
  assign atTop     = int'(curOrder) == POOL_LOG2;
  assign atNeed    = curOrder == needOrder;
  assign buddyFree = !atTop && freeMap[curNode ^ NW'(1)];

  // ---------------- state update ----------------
  always_ff @(posedge clk) begin
    if (!rstN) begin
      freeMap     <= {{(NODES - 2){1'b0}}, 1'b1};
      curNode     <= NW'(1);
      curOrder    <= '0;
      needOrder   <= '0;
      lastWasFree <= 1'b0;
      respBase    <= '0;
      respOrder   <= '0;
      respFail    <= 1'b0;
    end else begin
      if (ctl.loadAlloc) begin
        needOrder   <= allocNeed;
        curOrder    <= allocNeed;
        lastWasFree <= 1'b0;
      end
      if (ctl.loadFree) begin
        curNode     <= tNode;
        curOrder    <= tOrder;
        lastWasFree <= 1'b1;
      end
      if (ctl.stepUp) curOrder <= curOrder + ORD_W'(1);
      if (ctl.takeFound) begin
        freeMap[foundNode] <= 1'b0;
        curNode            <= foundNode;
      end
      if (ctl.splitStep) begin
        freeMap[{curNode[NW-2:0], 1'b1}] <= 1'b1;
        curNode  <= {curNode[NW-2:0], 1'b0};
        curOrder <= curOrder - ORD_W'(1);
      end
      if (ctl.mergeStep) begin
        freeMap[curNode ^ NW'(1)] <= 1'b0;
        curNode  <= curNode >> 1;
        curOrder <= curOrder + ORD_W'(1);
      end
      if (ctl.markFree) freeMap[curNode] <= 1'b1;
      if (ctl.respOk) begin
        respBase  <= baseOf(curNode, curOrder);
        respOrder <= curOrder;
        respFail  <= 1'b0;
      end
      if (ctl.respFail) begin
        respBase  <= '0;
        respOrder <= '0;
        respFail  <= 1'b1;
      end
    end
  end

  // ---------------- assertions ----------------
  // R9: a free node never has a free ancestor
  always @(posedge clk) begin
    if (rstN) begin
      for (int n = 2; n < NODES; n++) begin
        a_r9_no_nested_free: assert (!(freeMap[NW'(n)] && freeMap[NW'(n >> 1)]))
          else $error("nested free node %0d", n);
      end
    end
  end

  // R3 / R5: a granted block is taken, a released block is left free
  a_r3_resp_map: assert property (@(posedge clk) disable iff (!rstN)
    (respValid && !respFail) |->
      (freeMap[nodeOf(respBase, respOrder)] == lastWasFree));

endmodule

// File: rtl/buddy_ctrl.sv
module buddy_ctrl
  import buddy_pkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   allocValid,
  input  logic   freeValid,
  input  logic   allocBad,
  input  logic   freeBad,
  input  logic   found,
  input  logic   atTop,
  input  logic   atNeed,
  input  logic   buddyFree,
  output dpCtl_t ctl,
  output logic   ready,
  output logic   respValid
);

  ctlState_t state, nextState;

  always_comb begin
    ctl       = '0;
    nextState = state;
    unique case (state)
      ST_IDLE: begin
        if (allocValid) begin
          if (allocBad) begin
            ctl.respFail = 1'b1;
            nextState    = ST_DONE;
          end else begin
            ctl.loadAlloc = 1'b1;
            nextState     = ST_SEARCH;
          end
        end else if (freeValid) begin
          if (freeBad) begin
            ctl.respFail = 1'b1;
            nextState    = ST_DONE;
          end else begin
            ctl.loadFree = 1'b1;
            nextState    = ST_MERGE;
          end
        end
      end
      ST_SEARCH: begin
        if (found) begin
          ctl.takeFound = 1'b1;
          nextState     = ST_SPLIT;
        end else if (atTop) begin
          ctl.respFail = 1'b1;
          nextState    = ST_DONE;
        end else begin
          ctl.stepUp = 1'b1;
        end
      end
      ST_SPLIT: begin
        if (atNeed) begin
          ctl.respOk = 1'b1;
          nextState  = ST_DONE;
        end else begin
          ctl.splitStep = 1'b1;
        end
      end
      ST_MERGE: begin
        if (buddyFree) begin
          ctl.mergeStep = 1'b1;
        end else begin
          ctl.markFree = 1'b1;
          ctl.respOk   = 1'b1;
          nextState    = ST_DONE;
        end
      end
      ST_DONE: nextState = ST_IDLE;
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  assign ready     = state == ST_IDLE;
  assign respValid = state == ST_DONE;

  // R7: response lasts one cycle and is followed by readiness
  a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    respValid |=> (!respValid && ready));

  // R8: with both commands present, no release sequence starts
  a_r8_alloc_first: assert property (@(posedge clk) disable iff (!rstN)
    (ready && allocValid && freeValid) |=> (state != ST_MERGE));

endmodule

// File: rtl/buddy_alloc.sv
module buddy_alloc
  import buddy_pkg::*;
#(
  parameter int POOL_LOG2 = 8,
  localparam int ORD_W = $clog2(POOL_LOG2 + 1)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 allocValid,
  input  logic [POOL_LOG2:0]   allocSize,
  input  logic                 freeValid,
  input  logic [POOL_LOG2-1:0] freeBase,
  input  logic [ORD_W-1:0]     freeOrder,
  output logic                 ready,
  output logic                 respValid,
  output logic                 respFail,
  output logic [POOL_LOG2-1:0] respBase,
  output logic [ORD_W-1:0]     respOrder
);

  localparam int NW = POOL_LOG2 + 1;

  dpCtl_t ctl;
  logic   allocBad, freeBad, found, atTop, atNeed, buddyFree;

  buddy_ctrl ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .allocValid (allocValid),
    .freeValid  (freeValid),
    .allocBad   (allocBad),
    .freeBad    (freeBad),
    .found      (found),
    .atTop      (atTop),
    .atNeed     (atNeed),
    .buddyFree  (buddyFree),
    .ctl        (ctl),
    .ready      (ready),
    .respValid  (respValid)
  );

  buddy_dp #(.POOL_LOG2(POOL_LOG2)) dp_i (
    .clk        (clk),
    .rstN       (rstN),
    .ctl        (ctl),
    .allocSize  (allocSize),
    .freeBase   (freeBase),
    .freeOrder  (freeOrder),
    .respValid  (respValid),
    .allocBad   (allocBad),
    .freeBad    (freeBad),
    .found      (found),
    .atTop      (atTop),
    .atNeed     (atNeed),
    .buddyFree  (buddyFree),
    .respBase   (respBase),
    .respOrder  (respOrder),
    .respFail   (respFail)
  );

  // R2: a returned block is aligned to its own size
  a_r2_aligned: assert property (@(posedge clk) disable iff (!rstN)
    (respValid && !respFail) |->
      ((NW'(respBase) & ((NW'(1) << respOrder) - NW'(1))) == '0));

  // R4 / R6: a failure carries zero base and order
  a_r4_fail_zero: assert property (@(posedge clk) disable iff (!rstN)
    (respValid && respFail) |-> (respBase == '0 && respOrder == '0));

endmodule

// File: tb/buddy_alloc_tb_top.sv
module buddy_alloc_tb_top;

  localparam int LOG2  = 8;
  localparam int ORD_W = $clog2(LOG2 + 1);

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic            allocValid = 1'b0;
  logic [LOG2:0]   allocSize = '0;
  logic            freeValid = 1'b0;
  logic [LOG2-1:0] freeBase = '0;
  logic [ORD_W-1:0] freeOrder = '0;
  logic            ready, respValid, respFail;
  logic [LOG2-1:0] respBase;
  logic [ORD_W-1:0] respOrder;

  int checks = 0;
  int fails  = 0;

  typedef struct {
    bit    fail;
    int    base;
    int    ord;
    string tag;
  } exp_t;

  exp_t sb[$];
  exp_t cur;

  always #10 clk = ~clk;  // 50 MHz

  buddy_alloc #(.POOL_LOG2(LOG2)) dut_i (
    .clk(clk), .rstN(rstN),
    .allocValid(allocValid), .allocSize(allocSize),
    .freeValid(freeValid), .freeBase(freeBase), .freeOrder(freeOrder),
    .ready(ready), .respValid(respValid), .respFail(respFail),
    .respBase(respBase), .respOrder(respOrder)
  );

  // monitor: compare each response with the oldest expectation
  always @(negedge clk) begin
    if (rstN && respValid) begin
      checks++;
      if (sb.size() == 0) begin
        fails++;
        $display("FAIL R7: unexpected response fail=%0d base=%0d order=%0d, expected none",
                 respFail, respBase, respOrder);
      end else begin
        cur = sb.pop_front();
        if (respFail !== cur.fail || int'(respBase) != cur.base || int'(respOrder) != cur.ord) begin
          fails++;
          $display("FAIL %s: got fail=%0d base=%0d order=%0d, expected fail=%0d base=%0d order=%0d",
                   cur.tag, respFail, respBase, respOrder, cur.fail, cur.base, cur.ord);
        end
      end
    end
  end

  task automatic push(input bit f, input int b, input int o, input string tag);
    exp_t e;
    e.fail = f; e.base = b; e.ord = o; e.tag = tag;
    sb.push_back(e);
  endtask

  task automatic waitReady();
    @(negedge clk);
    while (!ready) @(negedge clk);
  endtask

  task automatic finishCmd();
    @(negedge clk);
    allocValid = 1'b0;
    freeValid  = 1'b0;
    checks++;
    if (ready !== 1'b0) begin  // R7 busy after acceptance
      fails++;
      $display("FAIL R7: ready=%0d after acceptance, expected 0", ready);
    end
    while (!ready) @(negedge clk);
  endtask

  task automatic doAlloc(input int size, input bit f, input int b, input int o,
                         input string tag);
    waitReady();
    push(f, b, o, tag);
    allocSize  = (LOG2 + 1)'(size);
    allocValid = 1'b1;
    finishCmd();
  endtask

  task automatic doFree(input int b, input int k, input bit f, input int eb,
                        input int eo, input string tag);
    waitReady();
    push(f, eb, eo, tag);
    freeBase  = LOG2'(b);
    freeOrder = ORD_W'(k);
    freeValid = 1'b1;
    finishCmd();
  endtask

  task automatic doBoth(input int size, input int b, input int k, input int eb,
                        input int eo, input string tag);
    waitReady();
    push(1'b0, eb, eo, tag);
    allocSize  = (LOG2 + 1)'(size);
    allocValid = 1'b1;
    freeBase   = LOG2'(b);
    freeOrder  = ORD_W'(k);
    freeValid  = 1'b1;
    finishCmd();
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not complete, expected completion");
    summary();
  end

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    checks++;
    if (ready !== 1'b1 || respValid !== 1'b0) begin  // R1
      fails++;
      $display("FAIL R1: ready=%0d respValid=%0d, expected 1 0", ready, respValid);
    end

    // R1 R3 worked case and lowest-address choice
    doAlloc(21, 0, 0, 5, "R3");
    doAlloc(32, 0, 32, 5, "R2");
    doAlloc(2, 0, 64, 1, "R3");
    doAlloc(3, 0, 68, 2, "R2");
    doAlloc(1, 0, 66, 0, "R3");
    // R4 rejected and unservable requests
    doAlloc(0, 1, 0, 0, "R4");
    doAlloc(300, 1, 0, 0, "R4");
    doAlloc(256, 1, 0, 0, "R4");
    doAlloc(128, 0, 128, 7, "R2");
    doAlloc(64, 1, 0, 0, "R4");
    doAlloc(1, 0, 67, 0, "R4");
    // R5 merging
    doFree(66, 0, 0, 66, 0, "R5");
    doFree(67, 0, 0, 66, 1, "R5");
    // R6 bad releases
    doFree(66, 0, 1, 0, 0, "R6");
    doFree(65, 1, 1, 0, 0, "R6");
    doFree(0, 9, 1, 0, 0, "R6");
    doFree(64, 2, 1, 0, 0, "R6");
    doFree(64, 1, 0, 64, 2, "R5");
    doFree(68, 2, 0, 64, 6, "R5");
    doFree(0, 5, 0, 0, 5, "R5");
    doFree(32, 5, 0, 0, 7, "R5");
    doFree(128, 7, 0, 0, 8, "R9");
    // R9 pool whole again
    doAlloc(256, 0, 0, 8, "R9");
    doAlloc(1, 1, 0, 0, "R4");
    doFree(0, 8, 0, 0, 8, "R5");
    doAlloc(1, 0, 0, 0, "R1");
    // R8 both commands at once
    doBoth(1, 0, 0, 1, 0, "R8");
    doFree(0, 0, 0, 0, 0, "R8");
    doFree(1, 0, 0, 0, 8, "R8");
    // R2 rounding at and above powers of two
    doAlloc(5, 0, 0, 3, "R2");
    doAlloc(8, 0, 8, 3, "R2");
    doAlloc(9, 0, 16, 4, "R2");

    repeat (4) @(negedge clk);
    checks++;
    if (sb.size() != 0) begin
      fails++;
      $display("FAIL R7: %0d responses missing, expected 0", sb.size());
    end
    summary();
  end

endmodule